// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter. The converter runs in its three-wire mode without a busy indicator. In that mode one line does two jobs: it is the convert trigger and it is the chip select. When the block gets a start request, it drives the convert line high. It holds the line high for a fixed, parameterised worst-case conversion time instead of polling for completion. It then drops the line. This makes the converter place its most significant bit on the serial data line before any clock edge.

The block then issues a burst of serial clock pulses from a divided system clock. It samples each bit late in the low phase of the clock, so the first bit is taken before the first rising edge. The bits are assembled most significant first. The finished word is offered on a valid/ready output. `valid_o` rises when the word is complete and stays high, with `data_o` held, until the consumer asserts `ready_i`. The word is transferred in any cycle where both are high, and the controller then returns to idle. Back-pressure only delays the return to idle. It never loses or alters the word. `busy_o` is high from the accepted start until that transfer.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset and whenever idle, `cnv_o`, `sck_o`, `valid_o` and `busy_o` are all low.
- R2: A `start_i` seen high in idle raises `cnv_o` and `busy_o` at the next clock edge. `busy_o` stays high until the word is transferred on the output handshake.
- R3: `cnv_o` stays high for exactly `CONV_CYCLES` system clock cycles per conversion, and `sck_o` is low the whole time.
- R4: After `cnv_o` falls, exactly `DATA_W` (16) rising edges appear on `sck_o`, with each half period lasting `SCK_HALF` system cycles. `sck_o` idles low.
- R5: The bit present on `sdo_i` once `cnv_o` has fallen is captured before the first `sck_o` rising edge and becomes `data_o[15]`. Each later bit is taken after a falling `sck_o` edge and fills the next lower position, so `data_o` equals the converter word, MSB first.
- R6: `valid_o` rises after the last falling `sck_o` edge. While `ready_i` is low, `valid_o` stays high and `data_o` stays unchanged.
- R7: The cycle with `valid_o` and `ready_i` both high transfers the word. After it the controller is idle, with `valid_o` and `busy_o` low.
- R8: A `start_i` asserted while `busy_o` is high is ignored. It causes no further rise of `cnv_o` and no extra word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion (acted on only when idle) |
| busy_o | output | 1 | Conversion or readout in progress |
| cnv_o | output | 1 | Convert trigger and chip select to the converter |
| sck_o | output | 1 | Serial clock to the converter, idles low |
| sdo_i | input | 1 | Serial data from the converter |
| data_o | output | DATA_W | Assembled conversion word |
| valid_o | output | 1 | Word available on `data_o` |
| ready_i | input | 1 | Consumer accepts the word |

## Verification
A converter model in the bench shifts out a chosen word. It places the MSB on the convert falling edge and moves to the next bit on each falling clock edge. The words used are all zeros and all ones, which catch a stuck capture. Alternating patterns, plus one word with only the two end bits set, catch bit-order and off-by-one errors at the MSB and LSB. Each word is run both with immediate acceptance and with a long hold-off of `ready_i`, which tells correct back-pressure apart from a one-shot strobe. A start pulse fired in the middle of a conversion separates a controller that ignores it from one that restarts or queues a second word.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_sck_gen.sv
module sar_sck_gen #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic sample_o,
  output logic fall_o
);
  logic sck_q;
  logic last_ph;

  generate
    if (SCK_HALF == 1) begin : g_no_div
      assign last_ph = 1'b1;
    end else begin : g_div
      localparam int PH_W = $clog2(SCK_HALF);
      logic [PH_W-1:0] ph_q;
      assign last_ph = (ph_q == PH_W'(SCK_HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ph_q <= '0;
        else if (!run_i)     ph_q <= '0;
        else if (last_ph)    ph_q <= '0;
        else                 ph_q <= ph_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sck_q <= 1'b0;
    else if (!run_i)       sck_q <= 1'b0;
    else if (last_ph)      sck_q <= ~sck_q;
  end

  assign sck_o    = sck_q;
  assign sample_o = run_i && !sck_q && last_ph;
  assign fall_o   = run_i &&  sck_q && last_ph;

  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sck_q);
endmodule

// File: rtl/sar_shift_capture.sv
module sar_shift_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (sample_i) sh_q <= {sh_q[DATA_W-2:0], sdo_i};
  end

  assign word_o = sh_q;

  // R5: the word only moves when a sample is taken
  a_r5_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(sh_q));
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20,
  parameter int SCK_HALF    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              cnv_o,
  output logic              sck_o,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i
);
  localparam int TMR_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  sar_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [BIT_W-1:0] bit_q;
  logic             cnv_q;
  logic             run;
  logic             sample;
  logic             fall;

  assign run = (state_q == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      bit_q   <= '0;
      cnv_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CONV;
          cnv_q   <= 1'b1;
          tmr_q   <= TMR_W'(CONV_CYCLES - 1);
        end
        ST_CONV: if (tmr_q == '0) begin
          state_q <= ST_READ;
          cnv_q   <= 1'b0;
          bit_q   <= '0;
        end else begin
          tmr_q   <= tmr_q - 1'b1;
        end
        ST_READ: if (fall) begin
          if (bit_q == LAST_BIT) state_q <= ST_DONE;
          else                   bit_q   <= bit_q + 1'b1;
        end
        ST_DONE: if (ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sar_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .sck_o    (sck_o),
    .sample_o (sample),
    .fall_o   (fall)
  );

  sar_shift_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample),
    .sdo_i    (sdo_i),
    .word_o   (data_o)
  );

  assign cnv_o   = cnv_q;
  assign valid_o = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cnv_o && !sck_o && !valid_o));
  a_r3_no_sck_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> !sck_o);
  a_r3_cnv_held: assert property (@(posedge clk) disable iff (!rst_n)
    (CONV_CYCLES > 1 && $rose(cnv_o)) |=> cnv_o);
  a_r6_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  a_r7_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> !busy_o);
  a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !valid_o) |=> !$rose(cnv_o));
endmodule

// File: tb/test_sar_readout_ctrl.sv
module test_sar_readout_ctrl;
  localparam int CLK_PERIOD  = 10;
  localparam int DATA_W      = 16;
  localparam int CONV_CYCLES = 20;
  localparam int SCK_HALF    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ready_i = 1'b0;
  logic sdo = 1'b0;
  logic busy_o, cnv_o, sck_o, valid_o;
  logic [DATA_W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_readout_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .SCK_HALF(SCK_HALF))
    i_sar_readout_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
      .cnv_o(cnv_o), .sck_o(sck_o), .sdo_i(sdo), .data_o(data_o),
      .valid_o(valid_o), .ready_i(ready_i));

  // converter model
  logic [DATA_W-1:0] adc_word = '0;
  logic [DATA_W-1:0] adc_sh = '0;
  always @(posedge cnv_o) sdo = 1'b0;
  always @(negedge cnv_o) begin adc_sh = adc_word; sdo = adc_word[DATA_W-1]; end
  always @(negedge sck_o) begin adc_sh = adc_sh << 1; sdo = adc_sh[DATA_W-1]; end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [DATA_W-1:0] exp_q[$];
  int cnv_hi = 0, cnv_rises = 0, sck_rises = 0, words = 0;
  logic prev_cnv = 0, prev_sck = 0, prev_valid = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cnv_o && !prev_cnv) begin cnv_rises++; sck_rises = 0; end
      if (cnv_o) begin
        cnv_hi++;
        check(!sck_o, "R3 sck low during convert", sck_o, 0);
      end else if (cnv_hi != 0) begin
        check(cnv_hi == CONV_CYCLES, "R3 convert high cycles", cnv_hi, CONV_CYCLES);
        cnv_hi = 0;
      end
      if (sck_o && !prev_sck) sck_rises++;
      if (valid_o && !prev_valid)
        check(sck_rises == DATA_W && !sck_o, "R4 sck pulse count", sck_rises, DATA_W);
      if (valid_o && ready_i) begin
        words++;
        if (exp_q.size() == 0) check(0, "R8 unexpected word", data_o, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          check(data_o == e, "R5 word MSB first", data_o, e);
        end
      end
      prev_cnv = cnv_o; prev_sck = sck_o; prev_valid = valid_o;
    end
  end

  task automatic run_conv(input logic [DATA_W-1:0] w, input int hold, input bit poke);
    logic [DATA_W-1:0] snap;
    adc_word = w;
    exp_q.push_back(w);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(cnv_o && busy_o, "R2 start raises cnv and busy", {cnv_o, busy_o}, 2'b11);
    if (poke) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    while (!valid_o) begin
      @(negedge clk);
      if (!valid_o) check(busy_o, "R2 busy during work", busy_o, 1);
    end
    snap = data_o;
    repeat (hold) begin
      @(negedge clk);
      check(valid_o && data_o == snap && busy_o, "R6 hold under back-pressure", data_o, snap);
    end
    ready_i = 1'b1;
    @(negedge clk); ready_i = 1'b0;
    check(!valid_o && !busy_o && !cnv_o && !sck_o, "R7 idle after transfer",
          {valid_o, busy_o, cnv_o, sck_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cnv_o && !sck_o && !valid_o && !busy_o, "R1 reset state",
          {cnv_o, sck_o, valid_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!cnv_o && !sck_o && !busy_o, "R1 idle after reset", {cnv_o, sck_o, busy_o}, 0);
    run_conv(16'h0000, 0, 0);
    run_conv(16'hFFFF, 7, 0);
    run_conv(16'hA5C3, 0, 0);
    run_conv(16'h8001, 12, 0);
    run_conv(16'h5555, 3, 1);
    repeat (100) @(negedge clk);
    check(cnv_rises == 5, "R8 start while busy ignored", cnv_rises, 5);
    check(words == 5 && exp_q.size() == 0, "R8 word count", words, 5);
    check(!busy_o && !cnv_o, "R1 quiet at end", {busy_o, cnv_o}, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule